// File: doc/BRIEF.md
# Latency FIFO Resynchronization Controller

This block sits on one received link, right after the clock-domain-crossing FIFO, and runs entirely in the system clock domain. It takes one frame per cycle, with a flag that marks idle frames. Its output is a frame stream of the same form. It also takes a delayed resync pulse that has a fixed timing relative to the machine orbit. A small state machine turns the writes and reads of a local single-clock FIFO on and off. The number of entries left in the FIFO then sets the link latency.

When a long run of idle frames arrives, the controller stops accepting input and lets the FIFO drain. It then stops reading, and a register outside the FIFO keeps showing the last idle frame. The first data frame after the idle run starts the writes again. The delayed resync pulse starts the reads again, so that first data frame leaves the block exactly at the pulse. From then on the latency stays fixed until the next idle run.

A monitor counts the cycles from the first data frame to the resync pulse. It compares this count with the one from the previous resync and raises a sticky error if the two differ. A separate sticky flag reports a write into a full FIFO.

Top module: `lf_resync`

## Requirements
- R1: After reset, frame_o is 0, idle_o is 0, and err_o and ovf_o are 0. The FIFO holds one data entry of value 0, and this entry is the first frame delivered.
- R2: In normal running, each input frame leaves the block with its idle flag unchanged, two clock edges after the edge that captured it. Runs of fewer than 8 consecutive idle frames pass through in the same way.
- R3: The 8th consecutive idle frame is written, and writes then stop. Idle frames after it are discarded. Once the FIFO has drained, the output shows the 8th idle frame.
- R4: Reads pause 24 cycles after the first idle frame of the run leaves the FIFO. From then on the output register holds its value, and it changes only when a frame is read from the FIFO.
- R5: The first data frame after the idle run restarts writes. Until reads are re-enabled, the output keeps showing the held idle frame.
- R6: A resync pulse while writes are on and reads are paused re-enables reads in that same cycle. The first data frame appears on the output after that clock edge, and the following frames follow in order with no gap.
- R7: A resync pulse at any other time has no effect: in normal running the two-edge relation of R2 (or the latency set by the last resync) is kept.
- R8: The monitor measures the cycles from the first data frame to the accepting resync pulse, in an 8-bit saturating count. err_o goes high and stays high when this count differs from the count of the previous resync. Equal counts leave err_o low.
- R9: A write into a full FIFO of 32 entries is dropped, and ovf_o goes high and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one frame per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | DW | Input frame payload |
| idle_i | input | 1 | Input frame is an idle frame |
| resync_i | input | 1 | Delayed resync pulse |
| frame_o | output | DW | Output frame payload |
| idle_o | output | 1 | Output frame is an idle frame |
| err_o | output | 1 | Sticky: the first-data-to-resync interval changed |
| ovf_o | output | 1 | Sticky: a write into a full FIFO was dropped |

## Verification
The checker watches these rules on every cycle:
- The output stays still in any cycle with no FIFO read.
- No idle frame is written while writes are stopped.
- Reads happen during the fill phase only on a resync pulse.
- A resync in normal running leaves the state unchanged.
- The error and overflow flags stay set, and the occupancy never goes above the depth.

Other behaviours can only be shown by the bench scenarios. These are the exact two-edge pass-through, the value of the held idle frame, the timing of the first data frame against the pulse, in-order delivery across several resyncs, and the change of the interval between resyncs that raises the error.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    LF_RUN   = 2'd0,  // read and write
    LF_DRAIN = 2'd1,  // writes stopped, reads continue
    LF_HOLD  = 2'd2,  // both stopped, output frozen
    LF_FILL  = 2'd3   // writes on, reads wait for resync
  } lf_state_e;
endpackage

// File: rtl/lf_store.sv
module lf_store #(
  parameter int DW    = 17,
  parameter int DEPTH = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_req_i,
  input  logic [DW-1:0]                din_i,
  output logic [DW-1:0]                dout_o,
  output logic                         pop_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         ovf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, wr_ok, pop;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop     = pop_req_i && !empty_o;
  assign wr_ok   = push_i && (!full || pop);
  assign dout_o  = mem_q[rd_ptr_q];
  assign pop_o   = pop;
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;

  // slot 0 preloaded: one entry at reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= AW'(1);
      rd_ptr_q <= '0;
      cnt_q    <= CW'(1);
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ok) begin
        mem_q[wr_ptr_q] <= din_i;
        wr_ptr_q        <= ptr_nxt(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= ptr_nxt(rd_ptr_q);
      case ({wr_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !wr_ok) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int IDLE_STOP = 8,
  parameter int READ_HOLD = 24
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      idle_i,
  input  logic      resync_i,
  input  logic      pop_i,
  input  logic      pop_idle_i,
  output lf_state_e state_o,
  output logic      wr_en_o,
  output logic      rd_req_o,
  output logic      fill_start_o,
  output logic      sync_o
);
  localparam int RW = $clog2(IDLE_STOP+1);
  localparam int GW = $clog2(READ_HOLD+1);

  lf_state_e     state_q, state_d;
  logic [RW-1:0] run_q;
  logic [GW-1:0] age_q;
  logic          stop_hit, age_done;

  assign stop_hit = idle_i && (run_q == RW'(IDLE_STOP-1));
  assign age_done = (age_q >= GW'(READ_HOLD));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LF_RUN:   if (stop_hit) state_d = LF_DRAIN;
      LF_DRAIN: if (!idle_i) state_d = LF_FILL;
                else if (age_done) state_d = LF_HOLD;
      LF_HOLD:  if (!idle_i) state_d = LF_FILL;
      LF_FILL:  if (resync_i) state_d = LF_RUN;
      default:  state_d = LF_RUN;
    endcase
  end

  assign fill_start_o = (state_q == LF_DRAIN || state_q == LF_HOLD) && !idle_i;
  assign sync_o       = (state_q == LF_FILL) && resync_i;
  assign wr_en_o      = (state_q == LF_RUN) || (state_q == LF_FILL) || fill_start_o;
  assign rd_req_o     = (state_q == LF_RUN) || (state_q == LF_DRAIN) || sync_o;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LF_RUN;
      run_q   <= '0;
      age_q   <= '0;
    end else begin
      state_q <= state_d;
      // consecutive idles accepted in normal running
      if (state_q == LF_RUN && idle_i && !stop_hit) run_q <= run_q + 1'b1;
      else                                         run_q <= '0;
      // cycles since first idle of the run left the FIFO
      if (pop_i && !pop_idle_i)                  age_q <= '0;
      else if (age_q == '0 && pop_i && pop_idle_i) age_q <= GW'(1);
      else if (age_q != '0 && !age_done)         age_q <= age_q + 1'b1;
    end
  end
endmodule

// File: rtl/lf_mon.sv
module lf_mon #(
  parameter int IW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_start_i,
  input  logic sync_i,
  output logic err_o
);
  logic [IW-1:0] cnt_q, prev_q;
  logic          busy_q, have_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
      busy_q <= 1'b0;
      have_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (fill_start_i) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (sync_i) begin
        busy_q <= 1'b0;
        prev_q <= cnt_q;
        have_q <= 1'b1;
        if (have_q && cnt_q != prev_q) err_q <= 1'b1;
      end else if (busy_q && cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/lf_resync.sv
module lf_resync
  import lf_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 32,
  parameter int IDLE_STOP = 8,
  parameter int READ_HOLD = 24,
  parameter int IW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] frame_i,
  input  logic          idle_i,
  input  logic          resync_i,
  output logic [DW-1:0] frame_o,
  output logic          idle_o,
  output logic          err_o,
  output logic          ovf_o
);
  localparam int EW = DW + 1;
  localparam int CW = $clog2(DEPTH+1);

  lf_state_e     state_w;
  logic          push_w, rd_req_w, pop_w, empty_w, fill_start_w, sync_w;
  logic [EW-1:0] dout_w;
  logic [CW-1:0] cnt_w;
  logic [EW-1:0] out_q;

  lf_ctrl #(.IDLE_STOP(IDLE_STOP), .READ_HOLD(READ_HOLD)) u_ctrl (
    .clk_i, .rst_ni, .idle_i, .resync_i,
    .pop_i(pop_w), .pop_idle_i(dout_w[DW]),
    .state_o(state_w), .wr_en_o(push_w), .rd_req_o(rd_req_w),
    .fill_start_o(fill_start_w), .sync_o(sync_w)
  );

  lf_store #(.DW(EW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .push_i(push_w), .pop_req_i(rd_req_w),
    .din_i({idle_i, frame_i}), .dout_o(dout_w), .pop_o(pop_w),
    .empty_o(empty_w), .cnt_o(cnt_w), .ovf_o(ovf_o)
  );

  lf_mon #(.IW(IW)) u_mon (
    .clk_i, .rst_ni, .fill_start_i(fill_start_w), .sync_i(sync_w), .err_o
  );

  // holding register: keeps last read frame while reads pause or FIFO is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= '0;
    else if (pop_w) out_q <= dout_w;
  end

  assign frame_o = out_q[DW-1:0];
  assign idle_o  = out_q[DW];
endmodule

// File: rtl/lf_resync_chk.sv
module lf_resync_chk
  import lf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input lf_state_e                  state_i,
  input logic                       idle_i,
  input logic                       resync_i,
  input logic                       push_i,
  input logic                       pop_i,
  input logic [$clog2(DEPTH+1)-1:0] cnt_i,
  input logic [DW:0]                out_i,
  input logic                       err_i,
  input logic                       ovf_i
);
  a_r3_no_idle_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == LF_DRAIN || state_i == LF_HOLD) && idle_i) |-> !push_i);

  a_r4_out_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(out_i));

  a_r6_fill_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LF_FILL && !resync_i) |-> !pop_i);

  a_r6_resync_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LF_FILL && resync_i) |=> state_i == LF_RUN);

  a_r7_resync_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == LF_RUN && resync_i && !idle_i) |=> state_i == LF_RUN);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind lf_resync lf_resync_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_w), .idle_i(idle_i),
  .resync_i(resync_i), .push_i(push_w), .pop_i(pop_w), .cnt_i(cnt_w),
  .out_i({idle_o, frame_o}), .err_i(err_o), .ovf_i(ovf_o)
);

// File: tb/sim_lf_resync.sv
`timescale 1ns/1ps
module sim_lf_resync;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] frame_i = 16'h00FF;
  logic          idle_i = 1'b1;
  logic          resync_i = 1'b0;
  logic [DW-1:0] frame_o;
  logic          idle_o, err_o, ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  lf_resync #(.DW(DW)) u0 (
    .clk_i, .rst_ni, .frame_i, .idle_i, .resync_i,
    .frame_o, .idle_o, .err_o, .ovf_o
  );

  task automatic chk(input string rq, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic drv(input logic idl, input logic [DW-1:0] v, input logic rs);
    @(negedge clk_i);
    idle_i = idl; frame_i = v; resync_i = rs;
    if (sb_on && !idl) exp_q.push_back(v);
    @(posedge clk_i);
    #1;
  endtask

  // scoreboard monitor: every data frame at the output in order, no gaps (R6)
  always @(negedge clk_i) begin
    if (sb_on && !idle_o) begin
      if (exp_q.size() == 0) chk("R6 unexpected data", {1'b0, frame_o}, '1);
      else chk("R6 order", {1'b0, frame_o}, {1'b0, exp_q.pop_front()});
    end
  end

  task automatic resync_seq(input int k, input logic [DW-1:0] base, input bit last);
    for (int i = 0; i < 70; i++) begin
      drv(1'b1, 16'h0300 + 16'(i), 1'b0);
      if (i == 40) begin
        chk("R3 held idle is 8th", {idle_o, frame_o}, {1'b1, 16'h0307});
        if (last) begin
          chk("R9 scoreboard drained", 17'(exp_q.size()), 17'd0);
          sb_on = 1'b0;
        end
      end
    end
    chk("R4 output frozen", {idle_o, frame_o}, {1'b1, 16'h0307});
    for (int j = 0; j <= k; j++) begin
      drv(1'b0, base + 16'(j), (j == k));
      if (j < k) begin
        if (j == 0 || j == k-1)
          chk("R5 idle kept during fill", {idle_o, frame_o}, {1'b1, 16'h0307});
      end else begin
        chk("R6 first data at resync", {idle_o, frame_o}, {1'b0, base});
      end
    end
    for (int j = 1; j <= 20; j++) drv(1'b0, base + 16'(k + j), 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [DW:0] prev;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset frame", {idle_o, frame_o}, '0);
    chk("R1 reset err", {16'd0, err_o}, '0);
    chk("R1 reset ovf", {16'd0, ovf_o}, '0);
    exp_q.push_back('0);   // preloaded entry (R1)
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    sb_on = 1'b1;

    // R2: two-edge pass-through with a short idle run
    prev = {1'b1, 16'h00FF};
    for (int i = 1; i <= 30; i++) begin
      logic idl;
      logic [DW-1:0] v;
      idl = (i >= 10 && i < 15);
      v = idl ? 16'h0200 + 16'(i) : 16'(i);
      drv(idl, v, 1'b0);
      if (i > 1) chk("R2 latency two edges", {idle_o, frame_o}, prev);
      prev = {idl, v};
    end
    // R7: resync in normal running has no effect
    for (int i = 31; i <= 36; i++) begin
      drv(1'b0, 16'(i), (i == 32 || i == 33));
      chk("R7 resync ignored", {idle_o, frame_o}, prev);
      prev = {1'b0, 16'(i)};
    end

    resync_seq(10, 16'h1000, 1'b0);
    chk("R8 no error on first interval", {16'd0, err_o}, '0);
    resync_seq(10, 16'h2000, 1'b0);
    chk("R8 equal interval keeps err low", {16'd0, err_o}, '0);
    resync_seq(12, 16'h3000, 1'b0);
    chk("R8 changed interval sets err", {16'd0, err_o}, 17'd1);
    chk("R9 no overflow yet", {16'd0, ovf_o}, '0);
    resync_seq(40, 16'h4000, 1'b1);
    chk("R9 overflow flagged", {16'd0, ovf_o}, 17'd1);
    chk("R8 err stays set", {16'd0, err_o}, 17'd1);
    repeat (5) @(posedge clk_i);
    finish_run();
  end
endmodule